// File: doc/BRIEF.md
# Vectored interrupt entry sequencer

This block sits next to a plain instruction counter and decides, at each instruction boundary, whether to divert execution into an interrupt handler. Request pulses from several interrupt classes are latched into per-class pending bits. When the instruction-complete strobe arrives, with the global enable set and at least one class pending, the block takes exactly one interrupt. The class with the lowest index wins.

Entry has four effects. The counter value present on the boundary cycle is saved as the return address. The enable is dropped and the chosen class's pending bit is cleared. One word is read from that class's slot in a vector table in low memory. On the cycle after the read, the fetched word is loaded as the new counter value, and the processor is switched to monitor mode. Requests that arrive while the enable is low stay pending until software sets the enable again.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset no read, load, monitor or acknowledge strobe is active, `ret_pc_o` is zero and `ien_o` is 1.
- R2: An interrupt is taken only on a cycle where `instr_done_i` is high, `ien_o` is high and some class is pending. No entry starts while `instr_done_i` is low.
- R3: On entry, `ret_pc_o` takes the `pc_i` value of the boundary cycle. It then holds that value until the next entry.
- R4: If several classes are pending, the lowest-numbered class is served first.
- R5: `vec_rd_o` is high for exactly the one cycle after the boundary cycle. During that cycle `vec_addr_o` equals class index times `WORD_BYTES`, counted from address 0.
- R6: On the cycle after the read, `pc_load_o` pulses for one cycle and `new_pc_o` carries the `vec_data_i` value returned for the read.
- R7: `to_monitor_o` pulses in the same cycle as `pc_load_o`.
- R8: Entry clears `ien_o`. While it is clear, boundaries take no interrupt and requests stay pending. After a `ien_set_i` pulse, the next boundary takes the pending class.
- R9: Taking an interrupt clears only that class's pending bit. The other pending classes are served at later boundaries.
- R10: During the read cycle, `irq_ack_o` is one-hot at the served class's bit position (bit i means class i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | NUM_CLASSES | Request pulses, one per class |
| instr_done_i | input | 1 | Instruction complete, counter already advanced |
| pc_i | input | ADDR_W | Current instruction counter |
| ien_set_i | input | 1 | Software sets the global interrupt enable |
| vec_rd_o | output | 1 | Vector table read strobe |
| vec_addr_o | output | ADDR_W | Vector slot address |
| vec_data_i | input | ADDR_W | Vector word, valid one cycle after the read |
| irq_ack_o | output | NUM_CLASSES | One-hot acknowledge of the served class |
| ret_pc_o | output | ADDR_W | Saved return counter |
| new_pc_o | output | ADDR_W | Handler address to load |
| pc_load_o | output | 1 | Counter load strobe |
| to_monitor_o | output | 1 | Switch to monitor mode strobe |
| ien_o | output | 1 | Global interrupt enable state |

## Verification
The bench builds the block with 4 classes, a 16-bit counter and 2-byte vector words. With 4 classes, every class can be pending at once, including the highest index, so the full priority order can be drained entry by entry. Because the word size is not 1, the address scaling is visible at the port. The memory model answers each read with a word derived from its address, so a wrong slot or a wrong sampling cycle shows up in `new_pc_o`.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_VREAD = 2'd1,
    ST_LOAD  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned NUM_CLASSES = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_CLASSES-1:0] req_i,
  input  logic [NUM_CLASSES-1:0] clr_i,
  output logic [NUM_CLASSES-1:0] pend_o
);
  logic [NUM_CLASSES-1:0] pend_q;

  // new request wins over a clear of the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | req_i;
  end

  assign pend_o = pend_q;

  a_r9_only_own_bit_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_q) & ~$past(clr_i) & ~pend_q) == '0));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int unsigned NUM_CLASSES = 8,
  localparam int unsigned IDX_W = $clog2(NUM_CLASSES)
) (
  input  logic [NUM_CLASSES-1:0] req_i,
  output logic [NUM_CLASSES-1:0] gnt_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic                   any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = NUM_CLASSES - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_gnt
    assign gnt_o[g] = any_o && (idx_o == IDX_W'(g));
  end

  always_comb begin
    if (any_o) begin
      a_r4_no_lower_req: assert ((req_i & (gnt_o - 1'b1)) == '0);
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned NUM_CLASSES = 8,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned WORD_BYTES  = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_CLASSES-1:0] irq_req_i,
  input  logic                   instr_done_i,
  input  logic [ADDR_W-1:0]      pc_i,
  input  logic                   ien_set_i,
  output logic                   vec_rd_o,
  output logic [ADDR_W-1:0]      vec_addr_o,
  input  logic [ADDR_W-1:0]      vec_data_i,
  output logic [NUM_CLASSES-1:0] irq_ack_o,
  output logic [ADDR_W-1:0]      ret_pc_o,
  output logic [ADDR_W-1:0]      new_pc_o,
  output logic                   pc_load_o,
  output logic                   to_monitor_o,
  output logic                   ien_o
);
  localparam int unsigned IDX_W = $clog2(NUM_CLASSES);

  seq_state_e             state_q, state_d;
  logic [IDX_W-1:0]       cls_q;
  logic [ADDR_W-1:0]      ret_q;
  logic                   ien_q;
  logic [NUM_CLASSES-1:0] pend, gnt, clr;
  logic [IDX_W-1:0]       win_idx;
  logic                   win_any;
  logic                   take;

  irq_pend #(.NUM_CLASSES(NUM_CLASSES)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (irq_req_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  irq_prio_arb #(.NUM_CLASSES(NUM_CLASSES)) u_arb (
    .req_i (pend),
    .gnt_o (gnt),
    .idx_o (win_idx),
    .any_o (win_any)
  );

  assign take = (state_q == ST_IDLE) && instr_done_i && ien_q && win_any;
  assign clr  = take ? gnt : '0;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (take) state_d = ST_VREAD;
      ST_VREAD: state_d = ST_LOAD;
      ST_LOAD:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cls_q   <= '0;
      ret_q   <= '0;
      ien_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      if (take) begin
        cls_q <= win_idx;
        ret_q <= pc_i;
      end
      // entry clear dominates a software set
      if (take)           ien_q <= 1'b0;
      else if (ien_set_i) ien_q <= 1'b1;
    end
  end

  assign vec_rd_o     = (state_q == ST_VREAD);
  assign vec_addr_o   = vec_rd_o ? ADDR_W'(cls_q) * ADDR_W'(WORD_BYTES) : '0;
  assign pc_load_o    = (state_q == ST_LOAD);
  assign to_monitor_o = pc_load_o;
  assign new_pc_o     = pc_load_o ? vec_data_i : '0;
  assign ret_pc_o     = ret_q;
  assign ien_o        = ien_q;

  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_ack
    assign irq_ack_o[g] = vec_rd_o && (cls_q == IDX_W'(g));
  end

  a_r2_entry_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_rd_o) |-> ($past(instr_done_i) && $past(ien_o)));
  a_r6_load_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd_o |=> (pc_load_o && !vec_rd_o));
  a_r8_enable_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd_o |-> !ien_o);
  a_r10_ack_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd_o |-> ($countones(irq_ack_o) == 1));
  a_r3_ret_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_rd_o |-> $stable(ret_pc_o));
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  localparam int NC = 4;
  localparam int AW = 16;
  localparam int WB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] irq_req = '0;
  logic          instr_done = 1'b0;
  logic [AW-1:0] pc = '0;
  logic          ien_set = 1'b0;
  logic          vec_rd;
  logic [AW-1:0] vec_addr;
  logic [AW-1:0] vec_data;
  logic [NC-1:0] irq_ack;
  logic [AW-1:0] ret_pc, new_pc;
  logic          pc_load, to_mon, ien;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irq_entry_seq #(.NUM_CLASSES(NC), .ADDR_W(AW), .WORD_BYTES(WB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req), .instr_done_i(instr_done),
    .pc_i(pc), .ien_set_i(ien_set), .vec_rd_o(vec_rd), .vec_addr_o(vec_addr),
    .vec_data_i(vec_data), .irq_ack_o(irq_ack), .ret_pc_o(ret_pc), .new_pc_o(new_pc),
    .pc_load_o(pc_load), .to_monitor_o(to_mon), .ien_o(ien)
  );

  // vector memory: one-cycle latency, content derived from address
  always_ff @(posedge clk) if (vec_rd) vec_data <= 16'hA000 | vec_addr;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_req(logic [NC-1:0] r);
    @(negedge clk) irq_req = r;
    @(negedge clk) irq_req = '0;
  endtask

  task automatic set_ien();
    @(negedge clk) ien_set = 1'b1;
    @(negedge clk) ien_set = 1'b0;
  endtask

  // boundary with entry expected for class c
  task automatic take_one(logic [AW-1:0] p, int c);
    @(negedge clk) begin instr_done = 1'b1; pc = p; end
    @(negedge clk) instr_done = 1'b0;
    chk("R5 vec_rd", 32'(vec_rd), 1);
    chk("R5 vec_addr", 32'(vec_addr), 32'(c * WB));
    chk("R10 ack", 32'(irq_ack), 32'(1 << c));
    chk("R3 ret_pc", 32'(ret_pc), 32'(p));
    chk("R8 ien cleared", 32'(ien), 0);
    @(negedge clk);
    chk("R6 pc_load", 32'(pc_load), 1);
    chk("R6 new_pc", 32'(new_pc), 32'(16'hA000 | 16'(c * WB)));
    chk("R7 to_monitor", 32'(to_mon), 1);
    chk("R5 single read", 32'(vec_rd), 0);
    @(negedge clk);
    chk("R6 single load", 32'(pc_load), 0);
    chk("R3 ret held", 32'(ret_pc), 32'(p));
  endtask

  // boundary that must not start an entry
  task automatic no_take(string tag, logic [AW-1:0] p);
    @(negedge clk) begin instr_done = 1'b1; pc = p; end
    @(negedge clk) instr_done = 1'b0;
    chk(tag, 32'(vec_rd), 0);
  endtask

  // {requests, counter}
  localparam logic [NC+AW-1:0] TBL [6] = '{
    {4'b0001, 16'h1000}, {4'b1000, 16'h1234}, {4'b0110, 16'h2002},
    {4'b1111, 16'h3ffe}, {4'b1010, 16'h4444}, {4'b0100, 16'hfff0}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 vec_rd", 32'(vec_rd), 0);
    chk("R1 pc_load", 32'(pc_load), 0);
    chk("R1 to_monitor", 32'(to_mon), 0);
    chk("R1 ack", 32'(irq_ack), 0);
    chk("R1 ret_pc", 32'(ret_pc), 0);
    chk("R1 ien", 32'(ien), 1);
    @(negedge clk) rst_n = 1'b1;

    // table walk: drain each request set in priority order (R4, R9)
    foreach (TBL[k]) begin
      logic [NC-1:0] left;
      int            step;
      left = TBL[k][NC+AW-1:AW];
      step = 0;
      pulse_req(left);
      while (left != '0) begin
        int lo;
        lo = 0;
        for (int i = NC - 1; i >= 0; i--) if (left[i]) lo = i;
        take_one(TBL[k][AW-1:0] + AW'(step), lo);
        chk("R4 R9 served bit", 32'(irq_ack === '0), 1);
        left[lo] = 1'b0;
        step++;
        set_ien();
      end
    end

    // R2: pending request without boundary strobe starts nothing
    pulse_req(4'b0100);
    repeat (4) begin
      @(negedge clk);
      chk("R2 no entry without boundary", 32'(vec_rd), 0);
    end
    take_one(16'h5550, 2);

    // R8: disabled, request stays pending, boundaries ignored
    pulse_req(4'b0010);
    no_take("R8 no entry while disabled", 16'h6000);
    no_take("R8 no entry while disabled", 16'h6002);
    chk("R3 ret held while disabled", 32'(ret_pc), 32'h5550);
    chk("R8 ien still clear", 32'(ien), 0);
    set_ien();
    chk("R8 ien set", 32'(ien), 1);
    take_one(16'h6004, 1);
    set_ien();

    // R9: request re-arriving for other class during entry is kept
    pulse_req(4'b0001);
    @(negedge clk) begin instr_done = 1'b1; pc = 16'h7000; irq_req = 4'b1000; end
    @(negedge clk) begin instr_done = 1'b0; irq_req = '0; end
    chk("R9 class0 entry", 32'(irq_ack), 32'b0001);
    repeat (2) @(negedge clk);
    set_ien();
    take_one(16'h7100, 3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule